// File: doc/BRIEF.md
# NOR Flash Write-Command Sequencer

This block interprets the bus write cycles aimed at a parallel NOR-style flash model. Each write carries an address, a 32-bit data word, an access size of one, two or four bytes and a byte-order flag. The low data byte of a write in the idle cycle is decoded as a command code. A small state machine then tracks the command in progress and a cycle index from 0 to 3. This lets multi-write sequences such as erase-with-confirm, lock/unlock and buffered block writes unfold over successive accesses.

The block owns a byte-addressed storage array, which it erases one sector at a time and programs one word at a time. It also keeps an 8-bit status register:

- bit 7 means ready;
- bit 5 means erase failed;
- bit 4 means program failed.

Every operation completes in the cycle it is accepted. When the array is marked read-only, the contents are left untouched and the failure is flagged in status. A side read port exposes the array bytes. A one-cycle error pulse reports malformed sequences.

Top module: `nor_cmd_fsm`

## Requirements
- R1: After synchronous reset the status register, the command register and the cycle index read 0, and the error pulse is low.
- R2: In cycle 0, codes 0x10, 0x40, 0x20, 0x60, 0x98 and 0xE8 are stored as the current command and move the cycle index to 1. Codes 0x70 and 0x90 are stored but leave the index at 0.
- R3: In cycle 0, code 0xFF or 0x00 returns to read-array mode, meaning command 0 and cycle 0. Code 0x50 also returns to read-array mode and writes status to 0x00.
- R4: Code 0x20 erases at once and sets status bit 7 (0x80). It writes 0xFF to every byte of the sector that holds the address, with the address rounded down to a sector boundary, and leaves other sectors alone. In cycle 1, 0xD0 returns to cycle 0 with bit 7 set, 0xFF returns to read-array mode, and any other value is an error.
- R5: In cycle 1 after 0x10 or 0x40, the write stores its data at the address. The size code sets the width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes. With the byte-order flag low, the least significant byte goes to the lowest address; with it high, the most significant byte goes there. Status bit 7 is then set, the index returns to 0, and the command code is kept.
- R6: Code 0xE8 sets bit 7. The cycle-1 data loads a word count N, and cycle 2 stores one word per write. The write that finds the count at zero moves the index to 3, so N+1 words are stored. In cycle 3, 0xD0 returns to cycle 0 with bit 7 set.
- R7: In cycle 3 of a buffered write, any value other than 0xD0 returns to read-array mode and raises the error pulse.
- R8: With read-only asserted, the array is never changed. An erase sets status bit 5 (0x20) and a program or buffered data write sets bit 4 (0x10). Bit 7 is set as it would be without read-only.
- R9: For lock/unlock, a cycle-1 value of 0xD0 or 0x01 returns to cycle 0 with bit 7 set. Any other value returns to read-array mode without an error pulse.
- R10: In query mode (0x98), writes other than 0xFF keep command 0x98 at cycle 1, and 0xFF returns to read-array mode.
- R11: An unknown code in cycle 0 returns to read-array mode and raises the error pulse for exactly one cycle. So does an erase cycle 1 that is neither 0xD0 nor 0xFF.
- R12: Status bits accumulate: once set, a bit stays set until a 0x50 command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one write per cycle |
| wr_addr | input | AW | Byte address of the write |
| wr_data | input | 32 | Write data; the low byte is the command code |
| wr_size | input | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| big_end | input | 1 | Byte order of program data, 1 = most significant byte first |
| read_only | input | 1 | Array write-protect |
| rd_addr | input | AW | Byte address for the side read port |
| rd_data | output | 8 | Array byte at rd_addr (combinational) |
| status | output | 8 | Status register |
| cmd_code | output | 8 | Current command code |
| cycle_idx | output | 2 | Current cycle index |
| seq_err | output | 1 | One-cycle pulse on an invalid sequence |

## Verification
The bench builds the block with a 64-byte array split into four 16-byte sectors and an 8-bit count. This keeps the array small enough to read back in full. It also places real neighbours on both sides of an erased sector, so the check can confirm that the erase stays inside its boundary. The four-byte writes at both byte orders, the count-then-confirm buffered write and the read-only paths all fall at sector offsets that can be checked byte by byte.

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm #(
  parameter int DEPTH      = 256,
  parameter int SECT_BYTES = 64,
  parameter int CNT_W      = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int SW = $clog2(SECT_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [1:0]    wr_size,
  input  logic          big_end,
  input  logic          read_only,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic [7:0]    status,
  output logic [7:0]    cmd_code,
  output logic [1:0]    cycle_idx,
  output logic          seq_err
);

  logic [7:0]       mem [DEPTH];
  logic [CNT_W-1:0] cnt, n_cnt;
  logic [7:0]       n_st, n_cmd;
  logic [1:0]       n_cyc;
  logic             n_err, do_prog, do_erase, go_idle;
  logic [7:0]       code;
  logic [2:0]       nbytes;

  assign code    = wr_data[7:0];
  assign nbytes  = (wr_size == 2'd0) ? 3'd1 : (wr_size == 2'd1) ? 3'd2 : 3'd4;
  assign rd_data = mem[rd_addr];

  always_comb begin
    n_cyc    = cycle_idx;
    n_cmd    = cmd_code;
    n_st     = status;
    n_cnt    = cnt;
    n_err    = 1'b0;
    do_prog  = 1'b0;
    do_erase = 1'b0;
    go_idle  = 1'b0;
    if (wr_en) begin
      case (cycle_idx)
        2'd0: case (code)
          8'h00, 8'hFF: go_idle = 1'b1;
          8'h10, 8'h40, 8'h60, 8'h98: begin n_cyc = 2'd1; n_cmd = code; end
          8'h20: begin
            do_erase = !read_only;
            n_st  = status | 8'h80 | (read_only ? 8'h20 : 8'h00);
            n_cyc = 2'd1;
            n_cmd = code;
          end
          8'h50: begin n_st = 8'h00; go_idle = 1'b1; end
          8'h70, 8'h90: n_cmd = code;
          8'hE8: begin n_st = status | 8'h80; n_cyc = 2'd1; n_cmd = code; end
          default: begin n_err = 1'b1; go_idle = 1'b1; end
        endcase
        2'd1: case (cmd_code)
          8'h10, 8'h40: begin
            do_prog = !read_only;
            n_st  = status | 8'h80 | (read_only ? 8'h10 : 8'h00);
            n_cyc = 2'd0;
          end
          8'h20: begin
            if (code == 8'hD0) begin n_cyc = 2'd0; n_st = status | 8'h80; end
            else if (code == 8'hFF) go_idle = 1'b1;
            else begin n_err = 1'b1; go_idle = 1'b1; end
          end
          8'hE8: begin n_cnt = wr_data[CNT_W-1:0]; n_cyc = 2'd2; end
          8'h60: begin
            if (code == 8'hD0 || code == 8'h01) begin n_cyc = 2'd0; n_st = status | 8'h80; end
            else go_idle = 1'b1;
          end
          8'h98: if (code == 8'hFF) go_idle = 1'b1;
          default: begin n_err = 1'b1; go_idle = 1'b1; end
        endcase
        2'd2: begin
          if (cmd_code == 8'hE8) begin
            do_prog = !read_only;
            n_st  = status | 8'h80 | (read_only ? 8'h10 : 8'h00);
            if (cnt == '0) n_cyc = 2'd3;
            n_cnt = cnt - 1'b1;
          end else begin
            n_err = 1'b1; go_idle = 1'b1;
          end
        end
        default: begin
          if (cmd_code == 8'hE8 && code == 8'hD0) begin n_cyc = 2'd0; n_st = status | 8'h80; end
          else begin n_err = 1'b1; go_idle = 1'b1; end
        end
      endcase
    end
    if (go_idle) begin
      n_cyc = 2'd0;
      n_cmd = 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status    <= 8'h00;
      cmd_code  <= 8'h00;
      cycle_idx <= 2'd0;
      cnt       <= '0;
      seq_err   <= 1'b0;
    end else begin
      status    <= n_st;
      cmd_code  <= n_cmd;
      cycle_idx <= n_cyc;
      cnt       <= n_cnt;
      seq_err   <= n_err;
    end
  end

  function automatic logic in_sector(input int i, input logic [AW-1:0] a);
    logic [AW-1:0] ia;
    ia = AW'(i);
    return (ia >> SW) == (a >> SW);
  endfunction

  function automatic logic [AW-1:0] lane_off(input int i, input logic [AW-1:0] a);
    logic [AW-1:0] ia;
    ia = AW'(i);
    return ia - a;
  endfunction

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      logic [AW-1:0] off;
      logic [1:0]    lane;
      off  = lane_off(i, wr_addr);
      lane = big_end ? 2'(nbytes - 3'd1 - 3'(off)) : off[1:0];
      if (do_erase && in_sector(i, wr_addr))
        mem[i] <= 8'hFF;
      else if (do_prog && (off < AW'(nbytes)))
        mem[i] <= wr_data[8*lane +: 8];
    end
  end

  assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en && cycle_idx == 2'd0 && wr_data[7:0] == 8'h50 |=> status == 8'h00 && cmd_code == 8'h00);

  assert_stat_cmd_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en && cycle_idx == 2'd0 && wr_data[7:0] == 8'h70 |=> cmd_code == 8'h70 && cycle_idx == 2'd0);

  assert_erase_ready_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en && cycle_idx == 2'd0 && wr_data[7:0] == 8'h20 |=> status[7] && cycle_idx == 2'd1);

  assert_prog_done_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en && cycle_idx == 2'd1 && (cmd_code == 8'h10 || cmd_code == 8'h40)
    |=> status[7] && cycle_idx == 2'd0);

  assert_buf_only_R6: assert property (@(posedge clk) disable iff (rst)
    cycle_idx[1] |-> cmd_code == 8'hE8);

  assert_ro_flag_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en && read_only && cycle_idx == 2'd1 && cmd_code == 8'h40 |=> status[4]);

  assert_err_idle_R11: assert property (@(posedge clk) disable iff (rst)
    seq_err |-> cycle_idx == 2'd0 && cmd_code == 8'h00);

  assert_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && cycle_idx == 2'd0 && wr_data[7:0] == 8'h50) |=> (status & $past(status)) == $past(status));

endmodule

// File: tb/nor_cmd_fsm_tb.sv
module nor_cmd_fsm_tb;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0] wr_size = 2'd0;
  logic big_end = 1'b0;
  logic read_only = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data, status, cmd_code;
  logic [1:0] cycle_idx;
  logic seq_err;
  int checks = 0;
  int errors = 0;

  nor_cmd_fsm #(.DEPTH(DEPTH), .SECT_BYTES(16), .CNT_W(8)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_size(wr_size), .big_end(big_end), .read_only(read_only), .rd_addr(rd_addr),
    .rd_data(rd_data), .status(status), .cmd_code(cmd_code), .cycle_idx(cycle_idx),
    .seq_err(seq_err));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d,
                    input logic [1:0] sz = 2'd0, input logic be = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_size = sz; big_end = be;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_byte(input string tag, input logic [AW-1:0] a, input logic [7:0] exp);
    rd_addr = a;
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic chk_state(input string tag, input logic [7:0] st, input logic [7:0] cm, input logic [1:0] cy);
    chk({tag, " status"}, status, st);
    chk({tag, " cmd"}, cmd_code, cm);
    chk({tag, " cycle"}, cycle_idx, cy);
  endtask

  task automatic t_reset;
    chk_state("R1 reset", 8'h00, 8'h00, 2'd0);
    chk("R1 err", seq_err, 0);
  endtask

  task automatic t_erase;
    for (int s = 0; s < 4; s++) begin
      wr(AW'(s * 16 + 5), 32'h20);
      wr(AW'(s * 16), 32'hD0);
    end
    chk_state("R4 confirm", 8'h80, 8'h20, 2'd0);
    chk_byte("R4 erased", 6'd0, 8'hFF);
    chk_byte("R4 erased", 6'd63, 8'hFF);
    wr(6'd20, 32'h40); wr(6'd20, 32'h11);
    wr(6'd40, 32'h40); wr(6'd40, 32'h22);
    wr(6'd15, 32'h40); wr(6'd15, 32'h33);
    wr(6'd21, 32'h20);
    chk_state("R4 erase cyc1", 8'h80, 8'h20, 2'd1);
    chk_byte("R4 sector hit", 6'd20, 8'hFF);
    chk_byte("R4 neighbour up", 6'd40, 8'h22);
    chk_byte("R4 neighbour down", 6'd15, 8'h33);
    wr(6'd21, 32'hFF);
    chk_state("R4 ff reset", 8'h80, 8'h00, 2'd0);
    chk("R4 ff no err", seq_err, 0);
    wr(6'd16, 32'h20); wr(6'd16, 32'h77);
    chk("R11 erase bad confirm err", seq_err, 1);
    chk_state("R11 erase bad", 8'h80, 8'h00, 2'd0);
    @(negedge clk);
    chk("R11 pulse one cycle", seq_err, 0);
  endtask

  task automatic t_program;
    wr(6'd0, 32'h50);
    chk_state("R3 clear", 8'h00, 8'h00, 2'd0);
    wr(6'd4, 32'h40); wr(6'd4, 32'hA1B2C3D4, 2'd2, 1'b0);
    chk_state("R5 done", 8'h80, 8'h40, 2'd0);
    chk_byte("R5 le0", 6'd4, 8'hD4);
    chk_byte("R5 le1", 6'd5, 8'hC3);
    chk_byte("R5 le2", 6'd6, 8'hB2);
    chk_byte("R5 le3", 6'd7, 8'hA1);
    wr(6'd8, 32'h40); wr(6'd8, 32'hA1B2C3D4, 2'd2, 1'b1);
    chk_byte("R5 be0", 6'd8, 8'hA1);
    chk_byte("R5 be3", 6'd11, 8'hD4);
    wr(6'd12, 32'h40); wr(6'd12, 32'h1234, 2'd1, 1'b1);
    chk_byte("R5 half be0", 6'd12, 8'h12);
    chk_byte("R5 half be1", 6'd13, 8'h34);
    wr(6'd14, 32'h10); wr(6'd14, 32'h5A, 2'd0, 1'b0);
    chk_byte("R5 byte", 6'd14, 8'h5A);
    chk_byte("R5 byte untouched", 6'd15, 8'h33);
  endtask

  task automatic t_buffer;
    wr(6'd32, 32'h20); wr(6'd32, 32'hD0);
    wr(6'd0, 32'h50);
    wr(6'd32, 32'hE8);
    chk_state("R6 start", 8'h80, 8'hE8, 2'd1);
    wr(6'd32, 32'd2);
    chk("R6 count cyc", cycle_idx, 2);
    wr(6'd32, 32'h11);
    wr(6'd33, 32'h22);
    chk("R6 still data", cycle_idx, 2);
    wr(6'd34, 32'h33);
    chk("R6 to confirm", cycle_idx, 3);
    wr(6'd32, 32'hD0);
    chk_state("R6 done", 8'h80, 8'hE8, 2'd0);
    chk_byte("R6 b0", 6'd32, 8'h11);
    chk_byte("R6 b1", 6'd33, 8'h22);
    chk_byte("R6 b2", 6'd34, 8'h33);
    chk_byte("R6 b3 untouched", 6'd35, 8'hFF);
    wr(6'd36, 32'hE8); wr(6'd36, 32'd0); wr(6'd36, 32'h44);
    chk("R7 at confirm", cycle_idx, 3);
    wr(6'd36, 32'h55);
    chk("R7 err", seq_err, 1);
    chk_state("R7 reset", 8'h80, 8'h00, 2'd0);
  endtask

  task automatic t_readonly;
    wr(6'd0, 32'h50);
    read_only = 1'b1;
    wr(6'd2, 32'h20);
    chk("R8 erase flag", status, 8'hA0);
    chk_byte("R8 erase kept", 6'd4, 8'hD4);
    wr(6'd2, 32'hD0);
    wr(6'd0, 32'h50);
    wr(6'd5, 32'h40); wr(6'd5, 32'h00);
    chk_state("R8 prog flag", 8'h90, 8'h40, 2'd0);
    chk_byte("R8 prog kept", 6'd5, 8'hC3);
    read_only = 1'b0;
    wr(6'd15, 32'h40); wr(6'd15, 32'h77);
    chk("R12 sticky", status, 8'h90);
    chk_byte("R12 prog after ro", 6'd15, 8'h77);
    wr(6'd0, 32'h50);
    chk("R12 cleared", status, 8'h00);
    read_only = 1'b1;
    wr(6'd33, 32'hE8);
    chk("R8 buf ready", status, 8'h80);
    wr(6'd33, 32'd0); wr(6'd33, 32'h99);
    chk_state("R8 buf flag", 8'h90, 8'hE8, 2'd3);
    chk_byte("R8 buf kept", 6'd33, 8'h22);
    wr(6'd33, 32'hD0);
    chk("R8 buf confirm", cycle_idx, 0);
    read_only = 1'b0;
  endtask

  task automatic t_lock_query_codes;
    wr(6'd0, 32'h50);
    wr(6'd0, 32'h60); wr(6'd0, 32'h01);
    chk_state("R9 unlock", 8'h80, 8'h60, 2'd0);
    wr(6'd0, 32'h50);
    wr(6'd0, 32'h60); wr(6'd0, 32'hD0);
    chk_state("R9 lock", 8'h80, 8'h60, 2'd0);
    wr(6'd0, 32'h60); wr(6'd0, 32'h33);
    chk("R9 bad no err", seq_err, 0);
    chk_state("R9 bad reset", 8'h80, 8'h00, 2'd0);
    wr(6'd0, 32'h98);
    chk_state("R10 enter", 8'h80, 8'h98, 2'd1);
    wr(6'd0, 32'h12);
    chk_state("R10 stay", 8'h80, 8'h98, 2'd1);
    wr(6'd0, 32'hFF);
    chk_state("R10 leave", 8'h80, 8'h00, 2'd0);
    wr(6'd0, 32'h70);
    chk_state("R2 status cmd", 8'h80, 8'h70, 2'd0);
    wr(6'd0, 32'h90);
    chk_state("R2 id cmd", 8'h80, 8'h90, 2'd0);
    wr(6'd0, 32'h00);
    chk_state("R3 zero code", 8'h80, 8'h00, 2'd0);
    wr(6'd0, 32'h70); wr(6'd0, 32'hFF);
    chk_state("R3 ff code", 8'h80, 8'h00, 2'd0);
    wr(6'd0, 32'h10);
    chk_state("R2 prog arm", 8'h80, 8'h10, 2'd1);
    wr(6'd0, 32'h50);
    chk("R2 second write programs", cycle_idx, 0);
    wr(6'd0, 32'h33);
    chk("R11 unknown err", seq_err, 1);
    chk_state("R11 unknown", 8'h80, 8'h00, 2'd0);
    @(negedge clk);
    chk("R11 pulse drop", seq_err, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_erase();
    t_program();
    t_buffer();
    t_readonly();
    t_lock_query_codes();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule